// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder with Acknowledge Sequencer

This block takes up to seven interrupt request lines from peripheral devices and reduces them to a single priority level. The highest active line wins. The level is registered and driven on three active-low priority pins. The block then compares the level with the three-bit interrupt mask from the processor status word. It raises a pending flag when the level may interrupt the current program.

When the processor signals that it takes the interrupt, the block runs an acknowledge cycle. It asserts IACK, freezes the level being serviced and waits for the interrupting device to return a vector number. A device that has never been programmed answers with the uninitialized vector 0x0F, and the block marks that case. If no device answers within the timeout window, the block supplies the spurious-interrupt vector 0x18 so the processor never hangs. At the end of the cycle the block presents the vector, its kind and the new mask value, which equals the serviced level. The processor loads that mask into its status word.

The sequencer has three states. `ST_IDLE` waits for a pending request together with the take signal; that transition is called *accept*. `ST_ACK` holds IACK high. It leaves on *respond* when the device strobes a vector, or on *time out* when the window expires. `ST_DONE` presents the result for one cycle and then returns to `ST_IDLE` on *finish*.

Top module: `irq_level_encoder`

## Requirements
- R1: Request bit k (k = 0..6) stands for level k+1. One clock edge after the request lines change, `ipl_n` carries the bitwise inverse of the highest active level.
- R2: With no request line active, the level is 0, `ipl_n` reads 3'b111 and `int_pend` is low.
- R3: `int_pend` is high exactly when the registered level is strictly greater than `sr_mask`, or when the level is 7, which is accepted whatever the mask.
- R4: In idle, `int_pend` and `cpu_take` high together on an edge make `iack` high from that edge on, and `ack_level` then shows the accepted level.
- R5: A `dev_valid` strobe sampled while `iack` is high ends the acknowledge. On the next edge `vec_valid` rises with `vec_out` equal to the device vector and `vec_kind` = 2'b00 (device), and `iack` drops.
- R6: A device response equal to 0x0F is passed through as `vec_out` = 0x0F with `vec_kind` = 2'b01 (uninitialized).
- R7: If no response is sampled during 16 consecutive `iack` cycles, `vec_valid` rises on the next edge with `vec_out` = 0x18 and `vec_kind` = 2'b10 (spurious). A response sampled in the 16th cycle still counts as a device response.
- R8: While `vec_valid` is high, `mask_new` equals the level that was acknowledged.
- R9: While `iack` is high, `ack_level` holds still whatever the request lines do, and `cpu_take` has no effect outside idle or without a pending request.
- R10: After reset `ipl_n` is 3'b111 and `iack`, `vec_valid` and `int_pend` are low.
- R11: `vec_valid` is a single-cycle pulse that never coincides with `iack`, and the block is idle on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 7 | Request lines, bit k = level k+1 |
| sr_mask | input | 3 | Interrupt mask from the status word |
| cpu_take | input | 1 | Processor takes the pending interrupt |
| dev_valid | input | 1 | Device vector strobe during acknowledge |
| dev_vector | input | 8 | Vector number from the device |
| ipl_n | output | 3 | Active-low encoded priority level |
| int_pend | output | 1 | Level beats the mask |
| iack | output | 1 | Acknowledge cycle in progress |
| ack_level | output | 3 | Level being acknowledged |
| vec_valid | output | 1 | Vector result valid (one cycle) |
| vec_out | output | 8 | Vector number for the processor |
| vec_kind | output | 2 | 00 device, 01 uninitialized, 10 spurious |
| mask_new | output | 3 | Mask to load when the vector is taken |

## Verification
Two functions can fall in the same cycle: a device response can arrive in the 16th and last sampled cycle of the acknowledge window, which is exactly the cycle in which the timeout expires. The bench drives the response strobe there on purpose and expects the device vector with kind 00 rather than the spurious vector. It checks the neighbouring delays on either side of that cycle, and random delays on both sides of the window are compared against a bench model. Request-line changes are also forced during the acknowledge, and the bench checks that the frozen level is kept.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_DONE = 2'd2
    } ack_state_t;

    localparam logic [1:0] KIND_DEV    = 2'b00;
    localparam logic [1:0] KIND_UNINIT = 2'b01;
    localparam logic [1:0] KIND_SPUR   = 2'b10;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NREQ = 7,
    parameter int LW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req,
    output logic [LW-1:0]   lvl_q
);

    logic [LW-1:0] lvl_d;

    // highest index wins because later iterations overwrite earlier ones
    always_comb begin
        lvl_d = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i]) begin
                lvl_d = LW'(i + 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

endmodule

// File: rtl/irq_mask_cmp.sv
module irq_mask_cmp #(
    parameter int NREQ = 7,
    parameter int LW   = 3
) (
    input  logic [LW-1:0] lvl,
    input  logic [LW-1:0] mask,
    output logic          pend
);

    localparam logic [LW-1:0] TOP_LVL = LW'(NREQ);

    always_comb begin
        if (lvl == TOP_LVL) begin
            pend = 1'b1;
        end else begin
            pend = (lvl > mask);
        end
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_enc_pkg::*;
#(
    parameter int          LW         = 3,
    parameter int          VW         = 8,
    parameter int          TIMEOUT    = 16,
    parameter logic [7:0]  UNINIT_VEC = 8'h0F,
    parameter logic [7:0]  SPUR_VEC   = 8'h18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend,
    input  logic          take,
    input  logic [LW-1:0] lvl,
    input  logic          dev_valid,
    input  logic [VW-1:0] dev_vector,
    output logic          iack,
    output logic [LW-1:0] ack_level,
    output logic          vec_valid,
    output logic [VW-1:0] vec_out,
    output logic [1:0]    vec_kind,
    output logic [LW-1:0] mask_new
);

    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
    localparam logic [VW-1:0] UNINIT_V = VW'(UNINIT_VEC);
    localparam logic [VW-1:0] SPUR_V   = VW'(SPUR_VEC);

    ack_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [LW-1:0] lvl_lat_q;
    logic [LW-1:0] mask_q;
    logic [VW-1:0] vec_q;
    logic [1:0]    kind_q;
    logic          accept;
    logic          expire;

    assign accept = pend && take;
    assign expire = (cnt_q == CNT_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, respond, time out, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_ACK;
            ST_ACK:  if (dev_valid || expire) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lvl_lat_q <= '0;
            mask_q    <= '0;
            vec_q     <= '0;
            kind_q    <= KIND_DEV;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        lvl_lat_q <= lvl;
                        cnt_q     <= '0;
                    end
                end
                ST_ACK: begin
                    if (dev_valid) begin
                        vec_q  <= dev_vector;
                        kind_q <= (dev_vector == UNINIT_V) ? KIND_UNINIT : KIND_DEV;
                        mask_q <= lvl_lat_q;
                    end else if (expire) begin
                        vec_q  <= SPUR_V;
                        kind_q <= KIND_SPUR;
                        mask_q <= lvl_lat_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    cnt_q <= '0;
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        iack      = 1'b0;
        vec_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACK:  iack = 1'b1;
            ST_DONE: vec_valid = 1'b1;
            default: ;
        endcase
        ack_level = lvl_lat_q;
        vec_out   = vec_q;
        vec_kind  = kind_q;
        mask_new  = mask_q;
    end

endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder #(
    parameter int         NREQ       = 7,
    parameter int         LW         = 3,
    parameter int         VW         = 8,
    parameter int         TIMEOUT    = 16,
    parameter logic [7:0] UNINIT_VEC = 8'h0F,
    parameter logic [7:0] SPUR_VEC   = 8'h18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] irq_req,
    input  logic [LW-1:0]   sr_mask,
    input  logic            cpu_take,
    input  logic            dev_valid,
    input  logic [VW-1:0]   dev_vector,
    output logic [LW-1:0]   ipl_n,
    output logic            int_pend,
    output logic            iack,
    output logic [LW-1:0]   ack_level,
    output logic            vec_valid,
    output logic [VW-1:0]   vec_out,
    output logic [1:0]      vec_kind,
    output logic [LW-1:0]   mask_new
);

    logic [LW-1:0] lvl_q;

    irq_prio_enc #(
        .NREQ (NREQ),
        .LW   (LW)
    ) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_req),
        .lvl_q (lvl_q)
    );

    assign ipl_n = ~lvl_q;

    irq_mask_cmp #(
        .NREQ (NREQ),
        .LW   (LW)
    ) u_cmp (
        .lvl  (lvl_q),
        .mask (sr_mask),
        .pend (int_pend)
    );

    irq_ack_fsm #(
        .LW         (LW),
        .VW         (VW),
        .TIMEOUT    (TIMEOUT),
        .UNINIT_VEC (UNINIT_VEC),
        .SPUR_VEC   (SPUR_VEC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (int_pend),
        .take       (cpu_take),
        .lvl        (lvl_q),
        .dev_valid  (dev_valid),
        .dev_vector (dev_vector),
        .iack       (iack),
        .ack_level  (ack_level),
        .vec_valid  (vec_valid),
        .vec_out    (vec_out),
        .vec_kind   (vec_kind),
        .mask_new   (mask_new)
    );

endmodule

// File: rtl/irq_level_encoder_chk.sv
module irq_level_encoder_chk #(
    parameter int         NREQ       = 7,
    parameter int         LW         = 3,
    parameter int         VW         = 8,
    parameter int         TIMEOUT    = 16,
    parameter logic [7:0] UNINIT_VEC = 8'h0F,
    parameter logic [7:0] SPUR_VEC   = 8'h18
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] irq_req,
    input logic [LW-1:0]   sr_mask,
    input logic            cpu_take,
    input logic [LW-1:0]   ipl_n,
    input logic            int_pend,
    input logic            iack,
    input logic [LW-1:0]   ack_level,
    input logic            vec_valid,
    input logic [VW-1:0]   vec_out,
    input logic [1:0]      vec_kind,
    input logic [LW-1:0]   mask_new
);

    logic [31:0] iack_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iack_run <= '0;
        end else if (iack) begin
            iack_run <= iack_run + 1;
        end else begin
            iack_run <= '0;
        end
    end

    AST_NO_REQ_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_n == '1) |-> !int_pend); // R2

    AST_ACK_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!iack && !vec_valid && int_pend && cpu_take) |=> iack); // R4

    AST_ACK_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && $past(iack)) |-> (ack_level == $past(ack_level))); // R9

    AST_SPUR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_kind == 2'b10) |-> (vec_out == VW'(SPUR_VEC))); // R7

    AST_UNINIT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_kind != 2'b10 && vec_out == VW'(UNINIT_VEC)) |-> (vec_kind == 2'b01)); // R6

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        iack |-> (iack_run < TIMEOUT)); // R7

    AST_MASK_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (mask_new == ack_level)); // R8

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && iack)); // R11

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> (!vec_valid && !iack)); // R11

    AST_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_n == '0) |-> int_pend); // R3

    logic unused_ok;
    assign unused_ok = ^{irq_req, sr_mask};

endmodule

bind irq_level_encoder irq_level_encoder_chk #(
    .NREQ       (NREQ),
    .LW         (LW),
    .VW         (VW),
    .TIMEOUT    (TIMEOUT),
    .UNINIT_VEC (UNINIT_VEC),
    .SPUR_VEC   (SPUR_VEC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .sr_mask   (sr_mask),
    .cpu_take  (cpu_take),
    .ipl_n     (ipl_n),
    .int_pend  (int_pend),
    .iack      (iack),
    .ack_level (ack_level),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .vec_kind  (vec_kind),
    .mask_new  (mask_new)
);

// File: tb/tb_irq_level_encoder.sv
`timescale 1ns/1ps
module tb_irq_level_encoder;

    localparam real CLK_PER = 20.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] irq_req = '0;
    logic [2:0] sr_mask = '0;
    logic       cpu_take = 1'b0;
    logic       dev_valid = 1'b0;
    logic [7:0] dev_vector = '0;
    logic [2:0] ipl_n;
    logic       int_pend;
    logic       iack;
    logic [2:0] ack_level;
    logic       vec_valid;
    logic [7:0] vec_out;
    logic [1:0] vec_kind;
    logic [2:0] mask_new;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PER / 2.0) clk = ~clk;

    irq_level_encoder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .sr_mask    (sr_mask),
        .cpu_take   (cpu_take),
        .dev_valid  (dev_valid),
        .dev_vector (dev_vector),
        .ipl_n      (ipl_n),
        .int_pend   (int_pend),
        .iack       (iack),
        .ack_level  (ack_level),
        .vec_valid  (vec_valid),
        .vec_out    (vec_out),
        .vec_kind   (vec_kind),
        .mask_new   (mask_new)
    );

    function automatic logic [2:0] model_level(input logic [6:0] r);
        logic [2:0] l = '0;
        for (int i = 0; i < 7; i++) if (r[i]) l = 3'(i + 1);
        return l;
    endfunction

    function automatic logic model_pend(input logic [2:0] l, input logic [2:0] m);
        return (l == 3'd7) || (l > m);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // run one acknowledge; delay >= 16 means no device answer
    task automatic do_ack(input logic [2:0] lvl, input int delay, input logic [7:0] v);
        logic [7:0] ev;
        logic [1:0] ek;
        cpu_take = 1'b1;
        tick();
        cpu_take = 1'b0;
        check(iack == 1'b1, "R4 iack", int'(iack), 1);
        check(ack_level == lvl, "R4 ack_level", int'(ack_level), int'(lvl));
        for (int i = 0; i < 16; i++) begin
            if (i == delay) begin
                dev_valid  = 1'b1;
                dev_vector = v;
            end
            tick();
            dev_valid = 1'b0;
            if (i == delay) break;
            if (i < 15) check(iack == 1'b1, "R7 iack held", int'(iack), 1);
        end
        if (delay < 16) begin
            ev = v;
            ek = (v == 8'h0F) ? 2'b01 : 2'b00;
        end else begin
            ev = 8'h18;
            ek = 2'b10;
        end
        check(vec_valid == 1'b1 && iack == 1'b0, "R5 vec_valid", int'({vec_valid, iack}), 2);
        check(vec_out == ev, (delay < 16) ? "R5 vector" : "R7 spurious vector", int'(vec_out), int'(ev));
        check(vec_kind == ek, (ek == 2'b01) ? "R6 kind" : "R7 kind", int'(vec_kind), int'(ek));
        check(mask_new == lvl, "R8 mask_new", int'(mask_new), int'(lvl));
        tick();
        check(vec_valid == 1'b0 && iack == 1'b0, "R11 pulse end", int'({vec_valid, iack}), 0);
    endtask

    initial begin : watchdog
        #(CLK_PER * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [2:0] l;
        void'($urandom(32'h1D5C));
        repeat (3) tick();
        // R10 reset state
        check(ipl_n == 3'b111, "R10 ipl_n", int'(ipl_n), 7);
        check(!iack && !vec_valid && !int_pend, "R10 flags", int'({iack, vec_valid, int_pend}), 0);
        rst_n = 1'b1;
        tick();

        // R1 each single line
        for (int k = 0; k < 7; k++) begin
            irq_req = 7'(1 << k);
            tick();
            check(ipl_n == ~3'(k + 1), "R1 single line", int'(ipl_n), int'(~3'(k + 1)));
        end
        irq_req = 7'b0010110;
        tick();
        check(ipl_n == ~3'd5, "R1 highest wins", int'(ipl_n), int'(~3'd5));

        // R2 no request
        irq_req = '0;
        tick();
        check(ipl_n == 3'b111 && !int_pend, "R2 idle pins", int'({ipl_n, int_pend}), 14);

        // R3 mask boundaries
        irq_req = 7'b0000100; sr_mask = 3'd3; tick();
        check(int_pend == 1'b0, "R3 equal masked", int'(int_pend), 0);
        irq_req = 7'b0001000; tick();
        check(int_pend == 1'b1, "R3 above mask", int'(int_pend), 1);
        irq_req = 7'b1000000; sr_mask = 3'd7; tick();
        check(int_pend == 1'b1, "R3 level 7 always", int'(int_pend), 1);

        // R9 take ignored without pending
        irq_req = 7'b0000010; sr_mask = 3'd5; tick();
        cpu_take = 1'b1; tick(); tick(); cpu_take = 1'b0;
        check(iack == 1'b0 && vec_valid == 1'b0, "R9 take ignored", int'({iack, vec_valid}), 0);

        // R4 R5 R8 normal response
        irq_req = 7'b0010000; sr_mask = 3'd2; tick();
        do_ack(3'd5, 0, 8'h40);
        // R6 uninitialized
        do_ack(3'd5, 3, 8'h0F);
        // R7 spurious and boundary of window
        do_ack(3'd5, 16, 8'h77);
        do_ack(3'd5, 15, 8'h55);
        do_ack(3'd5, 14, 8'h56);

        // R9 level frozen while request lines move
        irq_req = 7'b0000100; sr_mask = 3'd0; tick();
        cpu_take = 1'b1; tick(); cpu_take = 1'b0;
        irq_req = 7'b1000000;
        tick(); tick();
        check(iack == 1'b1 && ack_level == 3'd3, "R9 frozen level", int'(ack_level), 3);
        check(ipl_n == 3'b000, "R1 pins follow during ack", int'(ipl_n), 0);
        dev_valid = 1'b1; dev_vector = 8'h60; tick(); dev_valid = 1'b0;
        check(vec_valid && vec_out == 8'h60 && mask_new == 3'd3, "R8 frozen mask", int'(mask_new), 3);
        tick();

        // random encoder and mask
        for (int n = 0; n < 300; n++) begin
            irq_req = 7'($urandom);
            if (($urandom % 4) == 0) irq_req = '0;
            sr_mask = 3'($urandom);
            tick();
            l = model_level(irq_req);
            check(ipl_n == ~l, "R1 random level", int'(ipl_n), int'(~l));
            check(int_pend == model_pend(l, sr_mask), "R3 random pend", int'(int_pend), int'(model_pend(l, sr_mask)));
        end

        // random acknowledges
        for (int n = 0; n < 40; n++) begin
            logic [7:0] v;
            int d;
            do begin
                irq_req = 7'($urandom);
            end while (irq_req == '0);
            l = model_level(irq_req);
            sr_mask = (l == 3'd7) ? 3'($urandom) : 3'($urandom % int'(l));
            tick();
            v = (($urandom % 3) == 0) ? 8'h0F : 8'($urandom);
            d = int'($urandom % 20);
            do_ack(l, d, v);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule